// File: doc/BRIEF.md
# Interval and PWM Timer with Interrupt Flag

This block is an up-counter with a compare register that runs in one of two modes. In interval mode it counts from zero up to the compare value, then returns to zero. Each match sets a sticky request flag, and an enable bit passes that flag to a level-sensitive interrupt line. In PWM mode the counter wraps freely through its full range, and a waveform output stays high while the count is below the compare value. PWM mode never raises a request.

Counting advances only on cycles where the count-clock enable input is high, so a prescaler outside the block sets the rate. Software reaches the block through a single-cycle write port with two addresses:

- Address 0 is the control register.
- Address 1 is the compare register.

Software clears the flag by writing zero to the flag bit of the control register.

Top module: `pwm_irq_timer`

## Requirements
- R1: Control register (address 0) bit layout: bit 0 is run, bit 1 is mode (0 = interval, 1 = PWM), bit 2 is interrupt enable, bit 3 is the flag. While run is 1 and `tick` is high, the counter advances by one on the clock edge. Without `tick` it holds. A control write with bit 0 = 0 returns it to 0x00 on that edge, and it stays at 0x00 while stopped.
- R2: In interval mode, a tick taken while the counter equals the compare register (address 1) sets the flag on that edge, whatever the enable bit holds.
- R3: In interval mode, the counter goes to 0x00 on the tick where it matches, so the period is compare+1 ticks.
- R4: `irq_o` is 1 exactly when both the flag and the enable bit are 1.
- R5: A control write with bit 3 = 0 clears the flag. A write with bit 3 = 1 leaves the flag unchanged, so it cannot set it.
- R6: A match on the same edge as a control write with bit 0 = 0 does not set the flag.
- R7: Setting the enable bit while the flag is already 1 raises `irq_o` right after that write edge.
- R8: In PWM mode, a match never sets the flag.
- R9: If a match and a flag-clearing write fall on the same edge, the flag ends at 1.
- R10: In PWM mode, the counter wraps from 0xFF to 0x00. `pwm_o` is 1 while running and the count is below the compare value, and 0 otherwise or when not in PWM mode.
- R11: After reset, the counter, flag, enable, run and mode are 0, and `irq_o` and `pwm_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control, 1 = compare |
| wr_data | input | 8 | Write data |
| count_o | output | 8 | Current counter value |
| flag_o | output | 1 | Sticky interrupt request flag |
| irq_o | output | 1 | Level interrupt request |
| pwm_o | output | 1 | PWM waveform |

## Verification
Two pairs of events can land on one edge.

- A hardware match and a software flag clear on the same edge should leave the flag at 1.
- A match and a stop write on the same edge should leave the flag at 0.

The bench provokes both by ticking the counter until its value equals the compare register, then issuing the write together with the matching tick. A behavioural model judges the outcome: it applies the priority on every clock and checks the flag, the counter and `irq_o` after the edge. The rising enable with the flag already set is judged in the same cycle-by-cycle way.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        MODE_INTERVAL = 1'b0,
        MODE_PWM      = 1'b1
    } tmr_mode_e;

    typedef enum logic {
        ADDR_CTRL = 1'b0,
        ADDR_CMP  = 1'b1
    } tmr_addr_e;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_MODE = 1;
    localparam int CTRL_IE   = 2;
    localparam int CTRL_FLAG = 3;

    typedef struct packed {
        logic      flag_keep;
        logic      ie;
        tmr_mode_e mode;
        logic      run;
    } tmr_ctrl_t;

    function automatic tmr_ctrl_t decode_ctrl(input logic [3:0] bits);
        tmr_ctrl_t c;
        c.run       = bits[CTRL_RUN];
        c.mode      = tmr_mode_e'(bits[CTRL_MODE]);
        c.ie        = bits[CTRL_IE];
        c.flag_keep = bits[CTRL_FLAG];
        return c;
    endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         run,
    input  logic         stop_wr,
    input  tmr_mode_e    mode,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt,
    output logic         match
);
    logic at_cmp;
    assign at_cmp = (cnt == cmp);
    assign match  = run && tick && !stop_wr && (mode == MODE_INTERVAL) && at_cmp;

    always_ff @(posedge clk) begin
        if (rst || stop_wr || !run) begin
            cnt <= '0;
        end else if (tick) begin
            if (mode == MODE_INTERVAL && at_cmp) cnt <= '0;
            else                                 cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic ie,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    assign irq = flag & ie;
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         run,
    input  tmr_mode_e    mode,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    output logic         pwm
);
    assign pwm = run && (mode == MODE_PWM) && (cnt < cmp);
endmodule

// File: rtl/pwm_irq_timer.sv
module pwm_irq_timer
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wr_en,
    input  logic         wr_addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count_o,
    output logic         flag_o,
    output logic         irq_o,
    output logic         pwm_o
);
    logic        run_q;
    tmr_mode_e   mode_q;
    logic        ie_q;
    logic [W-1:0] cmp_q;

    logic      ctrl_wr, cmp_wr, stop_wr, flag_clr, match;
    tmr_ctrl_t ctrl_in;

    assign ctrl_in  = decode_ctrl(wr_data[3:0]);
    assign ctrl_wr  = wr_en && (tmr_addr_e'(wr_addr) == ADDR_CTRL);
    assign cmp_wr   = wr_en && (tmr_addr_e'(wr_addr) == ADDR_CMP);
    assign stop_wr  = ctrl_wr && !ctrl_in.run;
    assign flag_clr = ctrl_wr && !ctrl_in.flag_keep;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            mode_q <= MODE_INTERVAL;
            ie_q   <= 1'b0;
            cmp_q  <= '0;
        end else begin
            if (ctrl_wr) begin
                run_q  <= ctrl_in.run;
                mode_q <= ctrl_in.mode;
                ie_q   <= ctrl_in.ie;
            end
            if (cmp_wr) cmp_q <= wr_data;
        end
    end

    tmr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .run(run_q), .stop_wr(stop_wr),
        .mode(mode_q), .cmp(cmp_q), .cnt(count_o), .match(match)
    );

    tmr_flag u_flag (
        .clk(clk), .rst(rst), .set(match), .clr(flag_clr), .ie(ie_q),
        .flag(flag_o), .irq(irq_o)
    );

    tmr_pwm #(.W(W)) u_pwm (
        .run(run_q), .mode(mode_q), .cnt(count_o), .cmp(cmp_q), .pwm(pwm_o)
    );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic         wr_en,
    input logic         wr_addr,
    input logic         wr_run,
    input logic         wr_flag,
    input logic         run_q,
    input tmr_mode_e    mode_q,
    input logic [W-1:0] cmp_q,
    input logic [W-1:0] count_o,
    input logic         flag_o,
    input logic         irq_o
);
    logic ctrl_w, stop_w, clr_w, hit;
    assign ctrl_w = wr_en && (wr_addr == 1'b0);
    assign stop_w = ctrl_w && !wr_run;
    assign clr_w  = ctrl_w && !wr_flag;
    assign hit    = run_q && tick && (count_o == cmp_q);

    a_r1_pwm_advance: assert property (@(posedge clk) disable iff (rst)
        (run_q && tick && !stop_w && mode_q == MODE_PWM) |=> count_o == W'($past(count_o) + 1'b1));

    a_r1_stop_zero: assert property (@(posedge clk) disable iff (rst)
        stop_w |=> count_o == '0);

    a_r2_match_sets: assert property (@(posedge clk) disable iff (rst)
        (hit && !stop_w && mode_q == MODE_INTERVAL) |=> flag_o);

    a_r3_wrap_at_cmp: assert property (@(posedge clk) disable iff (rst)
        (hit && mode_q == MODE_INTERVAL) |=> count_o == '0);

    a_r4_no_flag_no_irq: assert property (@(posedge clk) disable iff (rst)
        !flag_o |-> !irq_o);

    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_w && !(hit && mode_q == MODE_INTERVAL && !stop_w)) |=> !flag_o);

    a_r6_stop_blocks: assert property (@(posedge clk) disable iff (rst)
        (stop_w && !flag_o) |=> !flag_o);

    a_r8_pwm_quiet: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_PWM && !flag_o) |=> !flag_o);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        (hit && clr_w && wr_run && mode_q == MODE_INTERVAL) |=> flag_o);
endmodule

bind pwm_irq_timer tmr_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_run(wr_data[tmr_pkg::CTRL_RUN]), .wr_flag(wr_data[tmr_pkg::CTRL_FLAG]),
    .run_q(run_q), .mode_q(mode_q), .cmp_q(cmp_q), .count_o(count_o),
    .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/test_pwm_irq_timer.sv
module test_pwm_irq_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] count_o;
    logic       flag_o, irq_o, pwm_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference state
    int m_cnt = 0, m_cmp = 0;
    bit m_run = 0, m_mode = 0, m_ie = 0, m_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_irq_timer i_pwm_irq_timer (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o), .pwm_o(pwm_o)
    );

    function automatic logic [7:0] ctl(bit run, bit mode, bit ie, bit keep);
        return {4'b0000, keep, ie, mode, run};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge(input bit we, input bit ad, input logic [7:0] d, input bit tk);
        bit stop = we && !ad && !d[0];
        bit clr  = we && !ad && !d[3];
        bit hit  = m_run && tk && !stop && !m_mode && (m_cnt == m_cmp);
        int ncnt = m_cnt;
        if (stop || !m_run) ncnt = 0;
        else if (tk) ncnt = (!m_mode && m_cnt == m_cmp) ? 0 : (m_cnt + 1) % 256;
        if (hit) m_flag = 1;
        else if (clr) m_flag = 0;
        m_cnt = ncnt;
        if (we && !ad) begin m_run = d[0]; m_mode = d[1]; m_ie = d[2]; end
        if (we && ad) m_cmp = int'(d);
    endtask

    task automatic compare_all();
        int exp_pwm = (m_run && m_mode && m_cnt < m_cmp) ? 1 : 0;
        check(int'(count_o) == m_cnt, "R1 count", int'(count_o), m_cnt);
        check(flag_o == m_flag, "R2 flag", int'(flag_o), int'(m_flag));
        check(irq_o == (m_flag && m_ie), "R4 irq", int'(irq_o), int'(m_flag && m_ie));
        check(int'(pwm_o) == exp_pwm, "R10 pwm", int'(pwm_o), exp_pwm);
    endtask

    task automatic step(input bit we, input bit ad, input logic [7:0] d, input bit tk);
        wr_en = we; wr_addr = ad; wr_data = d; tick = tk;
        @(posedge clk);
        model_edge(we, ad, d, tk);
        @(negedge clk);
        compare_all();
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic run_to_match();
        for (int i = 0; i < 300 && m_cnt != m_cmp; i++) step(0, 0, 8'h00, 1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11: reset state
        check(count_o == 8'h00 && !flag_o && !irq_o && !pwm_o, "R11 reset", int'(count_o), 0);

        // R2: match sets flag with enable off; R3 period cmp+1
        step(1, 1, 8'd3, 0);
        step(1, 0, ctl(1, 0, 0, 0), 0);
        for (int i = 0; i < 3; i++) step(0, 0, 8'h00, 1);
        check(count_o == 8'd3 && !flag_o, "R3 at compare", int'(count_o), 3);
        step(0, 0, 8'h00, 0);
        check(count_o == 8'd3, "R1 hold without tick", int'(count_o), 3);
        step(0, 0, 8'h00, 1);
        check(flag_o && count_o == 8'd0, "R2 flag set on match", int'(flag_o), 1);
        check(!irq_o, "R4 irq gated by enable", int'(irq_o), 0);

        // R7: enable while flag set
        step(1, 0, ctl(1, 0, 1, 1), 0);
        check(irq_o, "R7 immediate irq", int'(irq_o), 1);

        // R5: clear by writing 0, writing 1 does nothing
        step(1, 0, ctl(1, 0, 1, 0), 0);
        check(!flag_o && !irq_o, "R5 clear", int'(flag_o), 0);
        step(1, 0, ctl(1, 0, 1, 1), 0);
        check(!flag_o, "R5 write one no effect", int'(flag_o), 0);

        // R9: set beats clear on same edge
        run_to_match();
        step(1, 0, ctl(1, 0, 1, 0), 1);
        check(flag_o && irq_o, "R9 set wins over clear", int'(flag_o), 1);
        step(1, 0, ctl(1, 0, 1, 0), 0);

        // R6: stop on match edge blocks set
        run_to_match();
        step(1, 0, ctl(0, 0, 1, 1), 1);
        check(!flag_o && count_o == 8'd0, "R6 stop blocks set", int'(flag_o), 0);
        step(0, 0, 8'h00, 1);
        check(count_o == 8'd0, "R1 stopped stays zero", int'(count_o), 0);

        // R8/R10: PWM mode, full wrap
        step(1, 1, 8'h80, 0);
        step(1, 0, ctl(1, 1, 1, 0), 0);
        for (int i = 0; i < 300; i++) begin
            step(0, 0, 8'h00, 1);
            if (m_cnt == 0) check(count_o == 8'h00 && pwm_o, "R10 wrap", int'(count_o), 0);
        end
        check(!flag_o && !irq_o, "R8 no request in PWM", int'(flag_o), 0);

        // sparse ticks, compare 0 (match every tick) and 255
        step(1, 1, 8'h00, 0);
        step(1, 0, ctl(0, 0, 0, 0), 0);
        step(1, 0, ctl(1, 0, 1, 0), 0);
        for (int i = 0; i < 40; i++) begin
            step(0, 0, 8'h00, (i % 3) != 0);
            if ((i % 5) == 4) step(1, 0, ctl(1, 0, 1, 0), (i % 2) == 0);
        end
        step(1, 1, 8'hFF, 0);
        step(1, 0, ctl(1, 0, 0, 0), 0);
        for (int i = 0; i < 600; i++) step(0, 0, 8'h00, (i % 4) != 1);
        check(m_flag == flag_o, "R3 long period", int'(flag_o), int'(m_flag));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule